// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block watches a set of general-purpose input lines, grouped in byte-wide banks, and turns activity on them into interrupt requests. Every line has its own configuration: it can fire on a rising edge, a falling edge, both edges, a high level or a low level. Detected events are held in a per-line status bit. Software reads a raw view and an enable-filtered view of that status. It acknowledges edge events by writing ones to a per-bank clear register.

The host side is a plain byte-wide register port with an address, a write strobe, write data and combinational read data. Each register kind has a base address on a four-address stride. The bank number is added to that base. A single active-high interrupt line summarises every enabled, pending line.

Top module: `gib_irq_ctrl`

## Requirements
- R1: Each input passes through two synchronising flops. Edges are found by comparing the synchronised value with its value one cycle earlier. A change driven before clock edge 1 shows in the status after clock edge 3, and not after edge 2.
- R2: When a line's both-edges bit is 1, the line sets its status on every rising and every falling edge. Its sense and polarity bits are then ignored, so a steady level does not re-set the status after a clear.
- R3: With both-edges 0 and sense 1, the line is level-sensitive. Its status equals the active level one cycle after synchronisation: high when polarity is 1, low when polarity is 0. A clear write has no lasting effect while the level stays active.
- R4: With both-edges 0 and sense 0, the line is edge-sensitive. Polarity 1 latches on rising edges only, and polarity 0 latches on falling edges only.
- R5: The masked status is the raw status ANDed with the per-line enable bits. `irq_o` is the OR of every masked-status bit.
- R6: Address = 4*kind + bank. The kinds are 0 both-edges, 1 sense, 2 polarity, 3 enable, 4 raw status, 5 masked status and 6 clear. Line n is bit n%8 of bank n/8. Configuration registers read back what was written. Bank numbers of 3 or more, and kind 7, read as 0 and ignore writes.
- R7: A write to a bank's clear register clears the latched edge-mode status bits where the byte holds a 1. Bits where the byte holds a 0 are left unchanged.
- R8: When an edge is detected in the same cycle as a clear write to that bit, the bit stays set.
- R9: After reset, every configuration bit and every status bit is 0 and `irq_o` is low.
- R10: Raw status shows latched events whether or not the line is enabled. The clear register and both status registers read as 0 for the clear kind, and writes to either status kind are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_BANKS*8 | Asynchronous GPIO inputs, line n at bit n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
A pin change becomes visible in raw status, masked status and `irq_o` three rising edges after it is driven. A configuration or clear write affects registers right after the edge it is presented on. Reads are combinational from the address. The bench drives all inputs on the falling edge and advances its own cycle model at each rising edge. It compares `irq_o` and the register reads at the next falling edge, before driving anything new. The directed checks also test raw status right after edges 2 and 3, and they line a clear write up with the edge-3 latch to test the set-wins case.

// File: rtl/gib_pkg.sv
package gib_pkg;
    localparam int BYTE_W      = 8;
    localparam int BANK_STRIDE = 4;
    localparam int T_BOTH  = 0;
    localparam int T_SENSE = 1;
    localparam int T_POL   = 2;
    localparam int T_EN    = 3;
    localparam int T_RAW   = 4;
    localparam int T_MASK  = 5;
    localparam int T_CLR   = 6;
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.prev;

    AST_PREV_LAGS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        prev_o == $past(sync_o)); // R1
endmodule

// File: rtl/gib_bank_detect.sv
module gib_bank_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] sense_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } det_t;

    det_t         st_d, st_q;
    logic [W-1:0] rise, fall, lvl_mode, lvl_act, edge_evt;

    always_comb begin
        rise     = sync_i & ~prev_i;
        fall     = ~sync_i & prev_i;
        lvl_mode = ~both_i & sense_i;
        lvl_act  = (pol_i & sync_i) | (~pol_i & ~sync_i);
        edge_evt = (both_i & (rise | fall))
                 | (~both_i & ~sense_i & ((pol_i & rise) | (~pol_i & fall)));
        st_d      = st_q;
        st_d.stat = (lvl_mode & lvl_act)
                  | (~lvl_mode & ((st_q.stat & ~clr_i) | edge_evt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    AST_EDGE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_evt) & ~stat_o) == '0)); // R8
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lvl_mode) & (stat_o ^ $past(lvl_act))) == '0)); // R3
    AST_CLEAR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_o) & ~$past(clr_i) & ~$past(lvl_mode) & ~stat_o) == '0)); // R7
endmodule

// File: rtl/gib_regs.sv
module gib_regs
    import gib_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    input  logic [NUM_BANKS*BYTE_W-1:0] stat_i,
    output logic [BYTE_W-1:0]           rdata_o,
    output logic [NUM_BANKS*BYTE_W-1:0] both_o,
    output logic [NUM_BANKS*BYTE_W-1:0] sense_o,
    output logic [NUM_BANKS*BYTE_W-1:0] pol_o,
    output logic [NUM_BANKS*BYTE_W-1:0] en_o,
    output logic [NUM_BANKS*BYTE_W-1:0] clr_o
);
    localparam int LINES = NUM_BANKS * BYTE_W;

    typedef struct packed {
        logic [LINES-1:0] both;
        logic [LINES-1:0] sense;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] en;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [1:0]       bank;
    logic [ADDR_W-3:0] kind;
    logic             bank_ok;
    int               base;
    logic [LINES-1:0] masked;

    always_comb begin
        bank    = addr_i[1:0];
        kind    = addr_i[ADDR_W-1:2];
        bank_ok = int'(bank) < NUM_BANKS;
        base    = bank_ok ? int'(bank) * BYTE_W : 0;
        masked  = stat_i & cfg_q.en;

        cfg_d = cfg_q;
        clr_o = '0;
        if (wr_en_i && bank_ok) begin
            case (int'(kind))
                T_BOTH:  cfg_d.both[base +: BYTE_W]  = wdata_i;
                T_SENSE: cfg_d.sense[base +: BYTE_W] = wdata_i;
                T_POL:   cfg_d.pol[base +: BYTE_W]   = wdata_i;
                T_EN:    cfg_d.en[base +: BYTE_W]    = wdata_i;
                T_CLR:   clr_o[base +: BYTE_W]       = wdata_i;
                default: ;
            endcase
        end

        rdata_o = '0;
        if (bank_ok) begin
            case (int'(kind))
                T_BOTH:  rdata_o = cfg_q.both[base +: BYTE_W];
                T_SENSE: rdata_o = cfg_q.sense[base +: BYTE_W];
                T_POL:   rdata_o = cfg_q.pol[base +: BYTE_W];
                T_EN:    rdata_o = cfg_q.en[base +: BYTE_W];
                T_RAW:   rdata_o = stat_i[base +: BYTE_W];
                T_MASK:  rdata_o = masked[base +: BYTE_W];
                default: rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign both_o  = cfg_q.both;
    assign sense_o = cfg_q.sense;
    assign pol_o   = cfg_q.pol;
    assign en_o    = cfg_q.en;

    AST_CFG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(en_o)); // R6
endmodule

// File: rtl/gib_irq_ctrl.sv
module gib_irq_ctrl
    import gib_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BYTE_W-1:0] pin_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    output logic [BYTE_W-1:0]           rdata_o,
    output logic                        irq_o
);
    localparam int LINES = NUM_BANKS * BYTE_W;

    logic [LINES-1:0] sync, prev, both, sense, pol, en, clr, stat;

    gib_sync #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (sync),
        .prev_o (prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gib_bank_detect #(.W(BYTE_W)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_i  (sync[b*BYTE_W +: BYTE_W]),
            .prev_i  (prev[b*BYTE_W +: BYTE_W]),
            .both_i  (both[b*BYTE_W +: BYTE_W]),
            .sense_i (sense[b*BYTE_W +: BYTE_W]),
            .pol_i   (pol[b*BYTE_W +: BYTE_W]),
            .clr_i   (clr[b*BYTE_W +: BYTE_W]),
            .stat_o  (stat[b*BYTE_W +: BYTE_W])
        );
    end

    gib_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .stat_i  (stat),
        .rdata_o (rdata_o),
        .both_o  (both),
        .sense_o (sense),
        .pol_o   (pol),
        .en_o    (en),
        .clr_o   (clr)
    );

    assign irq_o = |(stat & en);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|en)); // R5
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat)); // R5
endmodule

// File: tb/gib_irq_ctrl_bench.sv
`timescale 1ns/10ps
module gib_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin_i = '0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [23:0] m_s1 = '0, m_s2 = '0, m_p = '0;
    logic [23:0] m_both = '0, m_sense = '0, m_pol = '0, m_en = '0, m_stat = '0;

    always #5 clk = ~clk;

    gib_irq_ctrl u_gib_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [23:0] f_next_stat(input logic [23:0] bo, se, po, s, p, st, clr);
        logic [23:0] rise, fall, lvl, act, evt;
        rise = s & ~p;
        fall = ~s & p;
        lvl  = ~bo & se;
        act  = (po & s) | (~po & ~s);
        evt  = (bo & (rise | fall)) | (~bo & ~se & ((po & rise) | (~po & fall)));
        return (lvl & act) | (~lvl & ((st & ~clr) | evt));
    endfunction

    function automatic logic [7:0] f_read(input logic [4:0] a);
        logic [23:0] v;
        int b;
        b = int'(a[1:0]);
        if (b >= 3) return 8'h00;
        case (int'(a[4:2]))
            0: v = m_both;
            1: v = m_sense;
            2: v = m_pol;
            3: v = m_en;
            4: v = m_stat;
            5: v = m_stat & m_en;
            default: v = '0;
        endcase
        v = v >> (8 * b);
        return v[7:0];
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [23:0] pins, input logic we, input logic [4:0] a, input logic [7:0] d);
        logic [23:0] clr;
        int b;
        pin_i = pins; wr_en_i = we; addr_i = a; wdata_i = d;
        @(posedge clk);
        b = int'(a[1:0]);
        clr = '0;
        if (we && a[4:2] == 3'd6 && b < 3) clr = {16'h0, d} << (8 * b);
        m_stat = f_next_stat(m_both, m_sense, m_pol, m_s2, m_p, m_stat, clr);
        m_p = m_s2; m_s2 = m_s1; m_s1 = pins;
        if (we && b < 3) begin
            case (int'(a[4:2]))
                0: m_both[8*b +: 8]  = d;
                1: m_sense[8*b +: 8] = d;
                2: m_pol[8*b +: 8]   = d;
                3: m_en[8*b +: 8]    = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en_i = 1'b0;
        chk({7'h0, irq_o}, {7'h0, |(m_stat & m_en)}, "R5 irq_o is OR of masked status");
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        addr_i = a;
        #0.1;
        chk(rdata_o, f_read(a), tag);
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 7; k++)
            for (int b = 0; b < 3; b++)
                rd(5'(4 * k + b), tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        tick(pin_i, 1'b1, a, d);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] pins;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({7'h0, irq_o}, 8'h00, "R9 irq low after reset");
        for (int a = 0; a < 32; a++) rd(5'(a), "R9 R6 all registers zero after reset");
        rst_n = 1'b1;
        tick('0, 1'b0, '0, '0);

        // R6 readback, unmapped bank, status registers read-only
        wr(5'd2, 8'hA5);
        addr_i = 5'd2; #0.1; chk(rdata_o, 8'hA5, "R6 both-edges bank2 readback");
        wr(5'd3, 8'h77);
        addr_i = 5'd3; #0.1; chk(rdata_o, 8'h00, "R6 bank3 reads zero");
        wr(5'd16, 8'hFF);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h00, "R10 raw status ignores writes");
        addr_i = 5'd24; #0.1; chk(rdata_o, 8'h00, "R10 clear register reads zero");
        wr(5'd2, 8'h00);

        // R1 latency, pin 0 both edges, enabled
        wr(5'd0, 8'h01);
        wr(5'd12, 8'h01);
        tick(24'h000001, 1'b0, '0, '0);
        tick(24'h000001, 1'b0, '0, '0);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h00, "R1 no status after edge 2");
        tick(24'h000001, 1'b0, '0, '0);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h01, "R1 status after edge 3");
        chk({7'h0, irq_o}, 8'h01, "R5 irq raised for enabled line");

        // R7 clear: zeros keep, ones clear
        wr(5'd24, 8'h00);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h01, "R7 zero byte leaves status");
        wr(5'd24, 8'h01);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h00, "R7 one clears status");

        // R8 edge coincides with clear
        wr(5'd24, 8'h00);
        tick(24'h000001, 1'b0, '0, '0);
        tick(24'h000001, 1'b0, '0, '0);
        tick(24'h000000, 1'b0, '0, '0);
        tick(24'h000000, 1'b0, '0, '0);
        tick(24'h000000, 1'b1, 5'd24, 8'h01);
        addr_i = 5'd16; #0.1; chk(rdata_o, 8'h01, "R8 edge wins over clear");

        // R3 level high on pin 9
        wr(5'd5, 8'h02); wr(5'd9, 8'h02); wr(5'd13, 8'h02);
        repeat (3) tick(24'h000200, 1'b0, '0, '0);
        addr_i = 5'd17; #0.1; chk(rdata_o, 8'h02, "R3 level high sets status");
        wr(5'd25, 8'h02);
        addr_i = 5'd17; #0.1; chk(rdata_o, 8'h02, "R3 clear has no lasting effect");
        repeat (3) tick(24'h000000, 1'b0, '0, '0);
        addr_i = 5'd17; #0.1; chk(rdata_o, 8'h00, "R3 status drops with level");

        // R4 falling-edge only on pin 17, R10 raw shows while disabled
        repeat (3) tick(24'h020000, 1'b0, '0, '0);
        addr_i = 5'd18; #0.1; chk(rdata_o, 8'h00, "R4 rising ignored with polarity 0");
        repeat (3) tick(24'h000000, 1'b0, '0, '0);
        addr_i = 5'd18; #0.1; chk(rdata_o, 8'h02, "R4 falling edge latched");
        addr_i = 5'd22; #0.1; chk(rdata_o, 8'h00, "R10 masked zero for disabled line");
        wr(5'd26, 8'h02);

        // R2 both-edges overrides level sense on pin 18
        wr(5'd6, 8'h04); wr(5'd10, 8'h04); wr(5'd2, 8'h04);
        repeat (3) tick(24'h040000, 1'b0, '0, '0);
        addr_i = 5'd18; #0.1; chk(rdata_o, 8'h04, "R2 rising edge latched");
        wr(5'd26, 8'h04);
        repeat (3) tick(24'h040000, 1'b0, '0, '0);
        addr_i = 5'd18; #0.1; chk(rdata_o, 8'h00, "R2 steady level ignored");
        repeat (3) tick(24'h000000, 1'b0, '0, '0);
        addr_i = 5'd18; #0.1; chk(rdata_o, 8'h04, "R2 falling edge latched");
        rd_all("R6 register map after directed cases");

        // constrained random mix
        pins = '0;
        for (int k = 0; k < 12; k++) wr(5'(k), 8'($urandom));
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) pins = pins ^ (24'd1 << $urandom_range(0, 23));
            if ($urandom_range(0, 4) == 0)
                tick(pins, 1'b1, 5'($urandom_range(0, 31)), 8'($urandom));
            else
                tick(pins, 1'b0, '0, '0);
            if (n % 16 == 0) rd_all("R2 R3 R4 R5 R7 R10 random register compare");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule